// File: doc/BRIEF.md
# Machine Trap and Return Controller

This block decides at every instruction boundary whether the hart leaves its normal flow. On a boundary (`step_i` high), it first checks the enabled pending interrupts. If none is taken, it checks the exception conditions of the instruction at `pc_i`. It then either lets the instruction retire, enters a machine-mode trap, or performs a trap return. The trap-entry state lives inside the block: the saved exception PC, the cause, the trap value, the machine status bits (global enable, previous enable, previous privilege) and the current privilege.

The instruction fetch and execute logic drives the boundary strobe together with decoded facts about the instruction:
- the PC and instruction word;
- an illegal flag;
- the load/store kind, size and effective address;
- the environment-call, breakpoint and trap-return strobes.

In the same cycle the block answers with a redirect request, a redirect target and a retire permission. The trap registers and privilege update on the following clock edge. The trap-vector base and the interrupt enable and pending vectors come from the surrounding register file.

Top module: `trap_ctrl`

## Requirements
- R1: While `rst_n` is low, `redirect_o` is 1 and `redirect_pc_o` is 0. After a reset, the privilege is machine (3), the global and previous interrupt enables are 0, the previous privilege is 0, and `mcause_o`, `mepc_o` and `mtval_o` are 0.
- R2: An interrupt of code c is taken on a boundary when all of the following hold: `mip_i[c]`, `mie_i[c]` and the global enable are set, and c is one of 0, 3, 4, 7, 8, 11. This applies in any privilege. No other bit position can cause a trap.
- R3: When several interrupts qualify, the order of preference is 11, 3, 7, 8, 0, 4. A qualifying interrupt wins over any exception of the instruction at the same boundary.
- R4: The exception codes are:
  - 0: fetch PC with bits [1:0] not zero;
  - 2: illegal, including a trap return in user mode;
  - 3: breakpoint;
  - 8: environment call from user mode;
  - 11: environment call from machine mode;
  - 4: misaligned load;
  - 6: misaligned store.
  When several apply, the earlier entry in this list wins.
- R5: `mem_size_i` encodes byte (0), halfword (1), word (2) and doubleword (3). An access is misaligned when its address is not a multiple of 1, 2, 4 or 8 respectively.
- R6: On a trap, `mtval_o` becomes:
  - the misaligned address, for codes 0, 4 and 6;
  - the zero-extended instruction word, for code 2;
  - 0 for every other exception and for every interrupt.
- R7: On a trap, `mepc_o` becomes `pc_i` with bits [1:0] cleared. For an interrupt, `pc_i` is the instruction not yet executed.
- R8: On a trap, `mcause_o` becomes {interrupt flag in bit 63, zeros, 4-bit code in bits [3:0]}.
- R9: On trap entry, the previous enable takes the global enable, the global enable clears, the previous privilege takes the current privilege, and the privilege becomes machine.
- R10: The redirect target on a trap is `mtvec_i` with bits [1:0] cleared. When `mtvec_i[1:0]` is 1 and the trap is an interrupt, the target is that base plus 4 times the code.
- R11: A trap return in machine mode does the following:
  - redirects to `mepc_o`;
  - copies the previous enable into the global enable;
  - sets the previous enable to 1;
  - takes the privilege from the previous privilege;
  - sets the previous privilege to user (0).
- R12: `retire_o` is 1 exactly on boundaries where no trap is taken. A trap return retires, and a trap taken on a boundary suppresses retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 64 | PC of the instruction at this boundary |
| insn_i | input | 32 | Instruction word |
| illegal_i | input | 1 | Instruction is undefined, unimplemented or a bad register access |
| load_i | input | 1 | Instruction is a load |
| store_i | input | 1 | Instruction is a store |
| mem_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| mem_addr_i | input | 64 | Effective address of the access |
| ecall_i | input | 1 | Environment call strobe |
| ebreak_i | input | 1 | Breakpoint strobe |
| mret_i | input | 1 | Trap return strobe |
| mtvec_i | input | 64 | Trap vector base with mode in bits [1:0] |
| mie_i | input | 12 | Interrupt enable vector |
| mip_i | input | 12 | Interrupt pending vector |
| redirect_o | output | 1 | Next PC comes from redirect_pc_o |
| redirect_pc_o | output | 64 | Redirect target |
| retire_o | output | 1 | Instruction at this boundary retires |
| trap_o | output | 1 | A trap is taken at this boundary |
| priv_o | output | 2 | Current privilege (0 user, 3 machine) |
| mstatus_mie_o | output | 1 | Global interrupt enable |
| mstatus_mpie_o | output | 1 | Previous interrupt enable |
| mstatus_mpp_o | output | 2 | Previous privilege |
| mepc_o | output | 64 | Saved exception PC |
| mcause_o | output | 64 | Trap cause |
| mtval_o | output | 64 | Trap value |

## Verification
The hardest state to reach from the ports is user mode with the global enable set, because the block only enters user mode through a trap return whose saved privilege is user. After a machine-mode trap, the bench therefore chains two returns: the first clears the saved privilege and sets the previous enable, and the second lands in user mode with interrupts enabled. From there it exercises an illegal user-mode return, interrupts that race an environment call, and unimplemented pending bits. A later part switches the vector base to vectored mode and checks that the interrupt offset applies while exceptions stay at the base.

// File: rtl/trap_pkg.sv
// Package: shared constants for the trap controller.
// Assumes a single hart with user and machine privilege only.
package trap_pkg;
    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam int unsigned CODE_W = 4;

    localparam logic [3:0] EXC_FETCH_MIS = 4'd0;
    localparam logic [3:0] EXC_ILLEGAL   = 4'd2;
    localparam logic [3:0] EXC_BREAK     = 4'd3;
    localparam logic [3:0] EXC_LOAD_MIS  = 4'd4;
    localparam logic [3:0] EXC_STORE_MIS = 4'd6;
    localparam logic [3:0] EXC_ECALL_U   = 4'd8;
    localparam logic [3:0] EXC_ECALL_M   = 4'd11;

    // Interrupt sources, highest preference first
    localparam int unsigned IRQ_SRCS = 6;
    localparam int unsigned IRQ_ORDER [IRQ_SRCS] = '{11, 3, 7, 8, 0, 4};
endpackage

// File: rtl/trap_irq_sel.sv
// Module: trap_irq_sel
// Picks the preferred enabled pending interrupt. Only the codes listed in
// trap_pkg::IRQ_ORDER can fire. Purely combinational.
module trap_irq_sel
    import trap_pkg::*;
#(
    parameter int unsigned NIRQ = 12
) (
    input  logic [NIRQ-1:0]   mie_i,
    input  logic [NIRQ-1:0]   mip_i,
    input  logic              gie_i,
    output logic              hit_o,
    output logic [CODE_W-1:0] code_o
);
    logic [IRQ_SRCS-1:0] src_ready;

    // One qualifier per implemented source
    for (genvar g = 0; g < IRQ_SRCS; g++) begin : g_src
        assign src_ready[g] = mip_i[IRQ_ORDER[g]] & mie_i[IRQ_ORDER[g]] & gie_i;
    end

    // Scan from lowest preference up so the most preferred one is kept
    always_comb begin
        code_o = '0;
        for (int i = IRQ_SRCS - 1; i >= 0; i--) begin
            if (src_ready[i]) code_o = CODE_W'(IRQ_ORDER[i]);
        end
    end

    assign hit_o = |src_ready;
endmodule

// File: rtl/trap_exc_sel.sv
// Module: trap_exc_sel
// Classifies the exception raised by one instruction and forms its trap
// value. Assumes the decoded strobes describe a single instruction.
// Purely combinational.
module trap_exc_sel
    import trap_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned ILEN = 32
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [ILEN-1:0]   insn_i,
    input  logic [1:0]        priv_i,
    input  logic              illegal_i,
    input  logic              load_i,
    input  logic              store_i,
    input  logic [1:0]        mem_size_i,
    input  logic [XLEN-1:0]   mem_addr_i,
    input  logic              ecall_i,
    input  logic              ebreak_i,
    input  logic              mret_i,
    output logic              hit_o,
    output logic [CODE_W-1:0] code_o,
    output logic [XLEN-1:0]   tval_o
);
    logic [2:0] size_mask;
    logic       addr_mis;
    logic       fetch_mis;
    logic       bad_insn;

    // Low address bits that must be zero for the access size
    always_comb begin
        case (mem_size_i)
            2'd0:    size_mask = 3'b000;
            2'd1:    size_mask = 3'b001;
            2'd2:    size_mask = 3'b011;
            default: size_mask = 3'b111;
        endcase
    end

    assign addr_mis  = |(mem_addr_i[2:0] & size_mask);
    assign fetch_mis = |pc_i[1:0];
    assign bad_insn  = illegal_i | (mret_i & (priv_i == PRIV_U));

    // Fixed precedence among the exception sources
    always_comb begin
        hit_o  = 1'b1;
        code_o = '0;
        tval_o = '0;
        if (fetch_mis) begin
            code_o = EXC_FETCH_MIS;
            tval_o = pc_i;
        end else if (bad_insn) begin
            code_o = EXC_ILLEGAL;
            tval_o = XLEN'(insn_i);
        end else if (ebreak_i) begin
            code_o = EXC_BREAK;
        end else if (ecall_i) begin
            code_o = (priv_i == PRIV_U) ? EXC_ECALL_U : EXC_ECALL_M;
        end else if (load_i && addr_mis) begin
            code_o = EXC_LOAD_MIS;
            tval_o = mem_addr_i;
        end else if (store_i && addr_mis) begin
            code_o = EXC_STORE_MIS;
            tval_o = mem_addr_i;
        end else begin
            hit_o = 1'b0;
        end
    end
endmodule

// File: rtl/trap_ctrl.sv
// Module: trap_ctrl
// Decides at each instruction boundary between retire, trap entry and trap
// return, and holds the machine trap state. Assumes the caller keeps the
// PC and applies redirect_pc_o when redirect_o is high. Synchronous
// active-low reset.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned ILEN = 32,
    parameter int unsigned NIRQ = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [ILEN-1:0] insn_i,
    input  logic            illegal_i,
    input  logic            load_i,
    input  logic            store_i,
    input  logic [1:0]      mem_size_i,
    input  logic [XLEN-1:0] mem_addr_i,
    input  logic            ecall_i,
    input  logic            ebreak_i,
    input  logic            mret_i,
    input  logic [XLEN-1:0] mtvec_i,
    input  logic [NIRQ-1:0] mie_i,
    input  logic [NIRQ-1:0] mip_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            retire_o,
    output logic            trap_o,
    output logic [1:0]      priv_o,
    output logic            mstatus_mie_o,
    output logic            mstatus_mpie_o,
    output logic [1:0]      mstatus_mpp_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mtval_o
);
    localparam int unsigned PAD_W = XLEN - CODE_W;

    logic              irq_hit;
    logic [CODE_W-1:0] irq_code;
    logic              exc_hit;
    logic [CODE_W-1:0] exc_code;
    logic [XLEN-1:0]   exc_tval;
    logic              take_irq;
    logic              take_exc;
    logic              do_mret;
    logic [XLEN-1:0]   vec_base;
    logic [XLEN-1:0]   trap_pc;

    trap_irq_sel #(.NIRQ(NIRQ)) u_irq (
        .mie_i  (mie_i),
        .mip_i  (mip_i),
        .gie_i  (mstatus_mie_o),
        .hit_o  (irq_hit),
        .code_o (irq_code)
    );

    trap_exc_sel #(.XLEN(XLEN), .ILEN(ILEN)) u_exc (
        .pc_i       (pc_i),
        .insn_i     (insn_i),
        .priv_i     (priv_o),
        .illegal_i  (illegal_i),
        .load_i     (load_i),
        .store_i    (store_i),
        .mem_size_i (mem_size_i),
        .mem_addr_i (mem_addr_i),
        .ecall_i    (ecall_i),
        .ebreak_i   (ebreak_i),
        .mret_i     (mret_i),
        .hit_o      (exc_hit),
        .code_o     (exc_code),
        .tval_o     (exc_tval)
    );

    // Boundary outcome: interrupts first, then exceptions, then return
    assign take_irq = step_i & irq_hit;
    assign take_exc = step_i & exc_hit & ~irq_hit;
    assign trap_o   = take_irq | take_exc;
    assign do_mret  = step_i & mret_i & ~trap_o;
    assign retire_o = step_i & ~trap_o;

    // Trap target: base, plus code offset for vectored interrupts
    assign vec_base = {mtvec_i[XLEN-1:2], 2'b00};
    always_comb begin
        trap_pc = vec_base;
        if (take_irq && mtvec_i[1:0] == 2'b01)
            trap_pc = vec_base + {{(PAD_W - 2){1'b0}}, irq_code, 2'b00};
    end

    // Next-PC request toward the fetch logic
    always_comb begin
        redirect_o    = ~rst_n | trap_o | do_mret;
        redirect_pc_o = '0;
        if (rst_n) redirect_pc_o = trap_o ? trap_pc : mepc_o;
    end

    // Trap state: reset, trap entry and trap return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_o         <= PRIV_M;
            mstatus_mie_o  <= 1'b0;
            mstatus_mpie_o <= 1'b0;
            mstatus_mpp_o  <= PRIV_U;
            mepc_o         <= '0;
            mcause_o       <= '0;
            mtval_o        <= '0;
        end else if (trap_o) begin
            priv_o         <= PRIV_M;
            mstatus_mie_o  <= 1'b0;
            mstatus_mpie_o <= mstatus_mie_o;
            mstatus_mpp_o  <= priv_o;
            mepc_o         <= {pc_i[XLEN-1:2], 2'b00};
            mcause_o       <= take_irq ? {1'b1, {(PAD_W - 1){1'b0}}, irq_code}
                                       : {{PAD_W{1'b0}}, exc_code};
            mtval_o        <= take_irq ? '0 : exc_tval;
        end else if (do_mret) begin
            priv_o         <= mstatus_mpp_o;
            mstatus_mie_o  <= mstatus_mpie_o;
            mstatus_mpie_o <= 1'b1;
            mstatus_mpp_o  <= PRIV_U;
        end
    end
endmodule

// File: rtl/trap_ctrl_chk.sv
// Module: trap_ctrl_chk
// Temporal checks on the trap controller ports, attached by bind.
module trap_ctrl_chk
    import trap_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_i,
    input logic            mret_i,
    input logic [XLEN-1:0] pc_i,
    input logic            redirect_o,
    input logic            retire_o,
    input logic            trap_o,
    input logic [1:0]      priv_o,
    input logic            mstatus_mie_o,
    input logic            mstatus_mpie_o,
    input logic [1:0]      mstatus_mpp_o,
    input logic [XLEN-1:0] mepc_o,
    input logic [XLEN-1:0] mcause_o
);
    p_trap_no_retire_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !retire_o);

    p_trap_redirects_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> redirect_o);

    p_trap_enters_m_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (priv_o == PRIV_M) && !mstatus_mie_o);

    p_trap_saves_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (mstatus_mpie_o == $past(mstatus_mie_o))
                   && (mstatus_mpp_o == $past(priv_o)));

    p_irq_needs_gie_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (!mcause_o[XLEN-1] || $past(mstatus_mie_o)));

    p_epc_saved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> mepc_o == {$past(pc_i[XLEN-1:2]), 2'b00});

    p_user_mret_traps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mret_i && priv_o == PRIV_U) |-> trap_o);
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
    localparam int XLEN = 64;

    localparam logic [2:0] OP_NOP = 3'd0, OP_ILL = 3'd1, OP_LD = 3'd2, OP_ST = 3'd3,
                           OP_ECL = 3'd4, OP_BRK = 3'd5, OP_RET = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] pc;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] insn;
        logic [11:0] ie;
        logic [11:0] ip;
        logic        redir;
        logic [31:0] tgt;
        logic        ret;
        logic        irq;
        logic [3:0]  code;
        logic [31:0] tval;
        logic [31:0] epc;
        logic [1:0]  priv;
        logic        gie;
    } vec_t;

    localparam int NV = 23;
    // mtvec = 0x200 direct for the whole table
    localparam vec_t VECS [NV] = '{
        '{OP_NOP, 32'h1000, 2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b0, 32'h0,    1'b1, 1'b0, 4'd0,  32'h0,        32'h0,    2'd3, 1'b0}, // R12
        '{OP_ECL, 32'h1004, 2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h200,  1'b0, 1'b0, 4'd11, 32'h0,        32'h1004, 2'd3, 1'b0}, // R4
        '{OP_RET, 32'h208,  2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h1004, 1'b1, 1'b0, 4'd11, 32'h0,        32'h1004, 2'd3, 1'b0}, // R11
        '{OP_RET, 32'h1004, 2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h1004, 1'b1, 1'b0, 4'd11, 32'h0,        32'h1004, 2'd0, 1'b1}, // R11
        '{OP_ECL, 32'h1008, 2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h200,  1'b0, 1'b0, 4'd8,  32'h0,        32'h1008, 2'd3, 1'b0}, // R4 R9
        '{OP_LD,  32'h20c,  2'd3, 32'h2004, 32'h0,        12'h0,   12'h0,   1'b1, 32'h200,  1'b0, 1'b0, 4'd4,  32'h2004,     32'h20c,  2'd3, 1'b0}, // R5 R6
        '{OP_ST,  32'h210,  2'd1, 32'h3001, 32'h0,        12'h0,   12'h0,   1'b1, 32'h200,  1'b0, 1'b0, 4'd6,  32'h3001,     32'h210,  2'd3, 1'b0}, // R5 R6
        '{OP_ST,  32'h214,  2'd2, 32'h3004, 32'h0,        12'h0,   12'h0,   1'b0, 32'h0,    1'b1, 1'b0, 4'd6,  32'h3001,     32'h210,  2'd3, 1'b0}, // R5
        '{OP_ILL, 32'h218,  2'd0, 32'h0,    32'hdeadbeef, 12'h0,   12'h0,   1'b1, 32'h200,  1'b0, 1'b0, 4'd2,  32'hdeadbeef, 32'h218,  2'd3, 1'b0}, // R6
        '{OP_BRK, 32'h21c,  2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h200,  1'b0, 1'b0, 4'd3,  32'h0,        32'h21c,  2'd3, 1'b0}, // R4
        '{OP_NOP, 32'h222,  2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h200,  1'b0, 1'b0, 4'd0,  32'h222,      32'h220,  2'd3, 1'b0}, // R7
        '{OP_LD,  32'h224,  2'd0, 32'h4003, 32'h0,        12'h0,   12'h0,   1'b0, 32'h0,    1'b1, 1'b0, 4'd0,  32'h222,      32'h220,  2'd3, 1'b0}, // R5
        '{OP_NOP, 32'h228,  2'd0, 32'h0,    32'h0,        12'h888, 12'h888, 1'b0, 32'h0,    1'b1, 1'b0, 4'd0,  32'h222,      32'h220,  2'd3, 1'b0}, // R2
        '{OP_RET, 32'h22c,  2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h220,  1'b1, 1'b0, 4'd0,  32'h222,      32'h220,  2'd3, 1'b0}, // R11
        '{OP_RET, 32'h220,  2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h220,  1'b1, 1'b0, 4'd0,  32'h222,      32'h220,  2'd0, 1'b1}, // R11
        '{OP_RET, 32'h230,  2'd0, 32'h0,    32'h30200073, 12'h0,   12'h0,   1'b1, 32'h200,  1'b0, 1'b0, 4'd2,  32'h30200073, 32'h230,  2'd3, 1'b0}, // R11
        '{OP_RET, 32'h204,  2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h230,  1'b1, 1'b0, 4'd2,  32'h30200073, 32'h230,  2'd0, 1'b1}, // R11
        '{OP_NOP, 32'h234,  2'd0, 32'h0,    32'h0,        12'h999, 12'h011, 1'b1, 32'h200,  1'b0, 1'b1, 4'd0,  32'h0,        32'h234,  2'd3, 1'b0}, // R3 R8
        '{OP_RET, 32'h200,  2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h234,  1'b1, 1'b1, 4'd0,  32'h0,        32'h234,  2'd0, 1'b1}, // R11
        '{OP_ECL, 32'h238,  2'd0, 32'h0,    32'h0,        12'h180, 12'h999, 1'b1, 32'h200,  1'b0, 1'b1, 4'd7,  32'h0,        32'h238,  2'd3, 1'b0}, // R3
        '{OP_RET, 32'h200,  2'd0, 32'h0,    32'h0,        12'h0,   12'h0,   1'b1, 32'h238,  1'b1, 1'b1, 4'd7,  32'h0,        32'h238,  2'd0, 1'b1}, // R11
        '{OP_NOP, 32'h23c,  2'd0, 32'h0,    32'h0,        12'h666, 12'h666, 1'b0, 32'h0,    1'b1, 1'b1, 4'd7,  32'h0,        32'h238,  2'd0, 1'b1}, // R2
        '{OP_NOP, 32'h23c,  2'd0, 32'h0,    32'h0,        12'h999, 12'h990, 1'b1, 32'h200,  1'b0, 1'b1, 4'd11, 32'h0,        32'h23c,  2'd3, 1'b0}  // R3
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            step_i = 1'b0;
    logic [XLEN-1:0] pc_i = '0;
    logic [31:0]     insn_i = '0;
    logic            illegal_i = 1'b0, load_i = 1'b0, store_i = 1'b0;
    logic [1:0]      mem_size_i = '0;
    logic [XLEN-1:0] mem_addr_i = '0;
    logic            ecall_i = 1'b0, ebreak_i = 1'b0, mret_i = 1'b0;
    logic [XLEN-1:0] mtvec_i = 64'h200;
    logic [11:0]     mie_i = '0, mip_i = '0;
    logic            redirect_o, retire_o, trap_o;
    logic [XLEN-1:0] redirect_pc_o, mepc_o, mcause_o, mtval_o;
    logic [1:0]      priv_o, mstatus_mpp_o;
    logic            mstatus_mie_o, mstatus_mpie_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_ctrl u_trap_ctrl (.*);

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one boundary at the falling edge with idle strobes elsewhere
    task automatic drive(input logic [2:0] op, input logic [31:0] pc, input logic [1:0] sz,
                         input logic [31:0] addr, input logic [31:0] insn,
                         input logic [11:0] ie, input logic [11:0] ip);
        @(negedge clk);
        step_i = 1'b1; pc_i = XLEN'(pc); mem_size_i = sz; mem_addr_i = XLEN'(addr);
        insn_i = insn; mie_i = ie; mip_i = ip;
        illegal_i = (op == OP_ILL); load_i = (op == OP_LD); store_i = (op == OP_ST);
        ecall_i = (op == OP_ECL); ebreak_i = (op == OP_BRK); mret_i = (op == OP_RET);
        #1;
    endtask

    task automatic idle();
        step_i = 1'b0; illegal_i = 1'b0; load_i = 1'b0; store_i = 1'b0;
        ecall_i = 1'b0; ebreak_i = 1'b0; mret_i = 1'b0; mie_i = '0; mip_i = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: redirect to zero held during reset, then reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 redirect in reset", XLEN'(redirect_o), 64'd1);
        chk("R1 target in reset", redirect_pc_o, 64'd0);
        rst_n = 1'b1;
        #1;
        chk("R1 priv", XLEN'(priv_o), 64'd3);
        chk("R1 gie", XLEN'(mstatus_mie_o), 64'd0);
        chk("R1 mcause", mcause_o, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            drive(v.op, v.pc, v.sz, v.addr, v.insn, v.ie, v.ip);
            chk($sformatf("R10 redirect v%0d", i), XLEN'(redirect_o), XLEN'(v.redir));
            chk($sformatf("R12 retire v%0d", i), XLEN'(retire_o), XLEN'(v.ret));
            if (v.redir) chk($sformatf("R10 target v%0d", i), redirect_pc_o, XLEN'(v.tgt));
            @(posedge clk); #1;
            idle();
            chk($sformatf("R8 mcause v%0d", i), mcause_o, {v.irq, 59'd0, v.code});
            chk($sformatf("R6 mtval v%0d", i), mtval_o, XLEN'(v.tval));
            chk($sformatf("R7 mepc v%0d", i), mepc_o, XLEN'(v.epc));
            chk($sformatf("R9 priv v%0d", i), XLEN'(priv_o), XLEN'(v.priv));
            chk($sformatf("R9 gie v%0d", i), XLEN'(mstatus_mie_o), XLEN'(v.gie));
        end

        // R9: previous-state fields after the last interrupt taken from user mode
        chk("R9 mpie", XLEN'(mstatus_mpie_o), 64'd1);
        chk("R9 mpp", XLEN'(mstatus_mpp_o), 64'd0);

        // R10: vectored mode, interrupt offset vs exception base
        drive(OP_RET, 32'h200, 2'd0, 32'h0, 32'h0, 12'h0, 12'h0);
        chk("R11 return target", redirect_pc_o, 64'h23c);
        @(posedge clk); #1; idle();
        mtvec_i = 64'h401;
        drive(OP_NOP, 32'h240, 2'd0, 32'h0, 32'h0, 12'h008, 12'h008);
        chk("R10 vectored irq target", redirect_pc_o, 64'h40c);
        @(posedge clk); #1; idle();
        chk("R8 vectored irq cause", mcause_o, {1'b1, 59'd0, 4'd3});
        drive(OP_ECL, 32'h40c, 2'd0, 32'h0, 32'h0, 12'h0, 12'h0);
        chk("R10 vectored exception target", redirect_pc_o, 64'h400);
        @(posedge clk); #1; idle();
        chk("R4 ecall machine", mcause_o, 64'd11);

        // R4: fetch misalignment outranks an illegal instruction
        drive(OP_ILL, 32'h242, 2'd0, 32'h0, 32'h12345678, 12'h0, 12'h0);
        @(posedge clk); #1; idle();
        chk("R4 fetch over illegal cause", mcause_o, 64'd0);
        chk("R6 fetch over illegal tval", mtval_o, 64'h242);

        // R1: reset in the middle of trap state
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R1 redirect mid reset", XLEN'(redirect_o), 64'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk("R1 mcause cleared", mcause_o, 64'd0);
        chk("R1 mepc cleared", mepc_o, 64'd0);
        chk("R1 mpie cleared", XLEN'(mstatus_mpie_o), 64'd0);
        chk("R1 priv machine", XLEN'(priv_o), 64'd3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule